// File: doc/BRIEF.md
# Programmable Pixel Clock Divider Pair

The block derives a pixel clock for each of two display FIFO channels from a chosen parent clock. Each channel has its own control word. All channels are written over one shared write port: a strobe, a channel index and a data word. The control word picks the parent source and marks the clock as internally generated. It also either passes the parent through undivided or divides it by a programmable ratio. The block produces two outputs per channel: a pixel clock level and a one-cycle enable that marks the start of each output period.

The block is clocked by the fastest parent, the reference clock. Source code 0 selects that reference clock itself, so every reference cycle counts as a parent cycle. Codes 1 to 3 select slower parents, each presented as a one-cycle tick on `src_tick_i`. For a reference-clock parent, odd ratios get an exact 50 % duty cycle: a flop on the falling edge delays the start of the high phase by half a cycle.

A new ratio, bypass setting or source never cuts into the period in progress. The channel keeps an active copy of these fields and reloads it only at the end of an output period. A write that arrives on that same edge is forwarded into the new period.

Top module: `pcd_pair`

## Requirements
- R1: The control word holds the divisor field in bits [4:0]. With the reference-clock source and bypass clear, a divisor value N gives an output period of N+2 reference cycles, for every N from 0 to 31 (ratios 2 to 33).
- R2: With the bypass bit (bit 5) set, the output follows the parent clock, whatever the divisor field holds. For the reference source, the period is one reference cycle, high for the first half.
- R3: After reset every control field is zero, so each channel divides the reference clock by 2 and `pix_int_o` is low.
- R4: For the reference source and every ratio, even or odd, the high time of `pix_clk_o` equals its low time, measured in half reference cycles.
- R5: The source field sits in bits [8:7]. Code 0 is the reference clock. Code k (1 to 3) counts ticks of `src_tick_i[k-1]`. With a tick source, the period is R ticks and the output is high for (R+1)/2 ticks.
- R6: The clock-type bit (bit 6) marks the clock as internally generated. It appears on that channel's `pix_int_o` from the clock edge that accepts the write.
- R7: A write reaches only the channel named by `wr_ch_i`; the other channel's output is unchanged.
- R8: A write that lands inside an output period leaves that period at its old length; the new settings apply from the next period.
- R9: A write accepted on the very edge that ends a period governs the period that starts on that edge.
- R10: `pix_en_o` is high for exactly one reference cycle per output period, starting on the edge where the period begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, also the fastest parent (source code 0) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control write strobe, one write per cycle |
| wr_ch_i | input | 1 | Channel addressed by the write |
| wr_data_i | input | 9 | Control word: [8:7] source, [6] internal type, [5] bypass, [4:0] divisor |
| src_tick_i | input | 3 | Parent ticks for source codes 1 to 3, one reference cycle wide |
| pix_clk_o | output | 2 | Pixel clock level per channel |
| pix_en_o | output | 2 | Start-of-period pulse per channel |
| pix_int_o | output | 2 | Stored clock-type bit per channel |

## Verification
Two events can fall in the same reference cycle: the end of a period, which reloads the active settings, and a control write. The bench places the write on that edge by counting reference cycles from a `pix_en_o` pulse. It then counts half cycles to the next rising edge of `pix_clk_o`. This count tells whether the new ratio was forwarded into the new period or held back for one more period. A write placed a few cycles earlier, mid-period, is judged the same way: the old period must complete at its old length.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int DIV_W  = 5;
  localparam int SEL_W  = 2;
  localparam int RAT_W  = DIV_W + 1;
  localparam int CTRL_W = SEL_W + 2 + DIV_W;
  localparam int NSRC   = 2 ** SEL_W;
  localparam logic [SEL_W-1:0] SRC_REF = '0;

  // full control word as written by software
  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic             internal;
    logic             bypass;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  // fields that shape the output waveform
  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic             bypass;
    logic [DIV_W-1:0] div;
  } timing_t;

  function automatic timing_t timing_of(ctrl_t c);
    timing_t t;
    t.src    = c.src;
    t.bypass = c.bypass;
    t.div    = c.div;
    return t;
  endfunction

  // parent cycles per output period
  function automatic logic [RAT_W-1:0] ratio_of(timing_t t);
    return t.bypass ? RAT_W'(1) : RAT_W'(t.div) + RAT_W'(2);
  endfunction

  // parent cycles the output stays high (rounded up)
  function automatic logic [RAT_W-1:0] high_of(logic [RAT_W-1:0] r);
    return (r + RAT_W'(1)) >> 1;
  endfunction

endpackage

// File: rtl/pcd_ctrl_bank.sv
module pcd_ctrl_bank
  import pcd_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CHW-1:0]        wr_ch_i,
  input  ctrl_t                 wr_data_i,
  output ctrl_t [NCH-1:0]       shadow_o,
  output logic  [NCH-1:0]       hit_o
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_reg
    assign hit_o[ch] = wr_en_i && (wr_ch_i == CHW'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         shadow_o[ch] <= '0;
      else if (hit_o[ch])  shadow_o[ch] <= wr_data_i;
    end
  end

endmodule

// File: rtl/pcd_src_sel.sv
module pcd_src_sel
  import pcd_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NSRC-2:0]  ticks_i,
  output logic             tick_o
);

  always_comb begin
    if (sel_i == SRC_REF) tick_o = 1'b1;
    else                  tick_o = ticks_i[sel_i - SEL_W'(1)];
  end

endmodule

// File: rtl/pcd_divider.sv
module pcd_divider
  import pcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  timing_t          shadow_i,
  input  logic             hit_i,
  input  timing_t          wr_i,
  input  logic [NSRC-2:0]  ticks_i,
  output logic             pix_clk_o,
  output logic             pix_en_o,
  output logic             period_end_o,
  output logic             tick_o,
  output logic [RAT_W-1:0] ratio_o
);

  timing_t          act_q;
  logic [RAT_W-1:0] cnt_q;
  logic             hi_pos_q;
  logic             hi_neg_q;
  logic             en_q;
  logic [RAT_W-1:0] last_w;
  timing_t          next_w;
  logic             half_step_w;

  pcd_src_sel u_sel (
    .sel_i   (act_q.src),
    .ticks_i (ticks_i),
    .tick_o  (tick_o)
  );

  assign ratio_o      = ratio_of(act_q);
  assign last_w       = ratio_o - RAT_W'(1);
  assign period_end_o = tick_o && (cnt_q == last_w);
  // a write on the closing edge is forwarded into the new period
  assign next_w       = hit_i ? wr_i : shadow_i;
  assign half_step_w  = ratio_o[0] && (act_q.src == SRC_REF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '0;
      cnt_q    <= '0;
      hi_pos_q <= 1'b1;
      en_q     <= 1'b0;
    end else begin
      en_q <= period_end_o;
      if (period_end_o) begin
        act_q    <= next_w;
        cnt_q    <= '0;
        hi_pos_q <= 1'b1;
      end else if (tick_o) begin
        cnt_q    <= cnt_q + RAT_W'(1);
        hi_pos_q <= (cnt_q + RAT_W'(1)) < high_of(ratio_o);
      end
    end
  end

  // falling-edge copy delays the rise by half a cycle for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_neg_q <= 1'b0;
    else         hi_neg_q <= hi_pos_q;
  end

  always_comb begin
    if (act_q.bypass)     pix_clk_o = clk_i & tick_o;
    else if (half_step_w) pix_clk_o = hi_pos_q & hi_neg_q;
    else                  pix_clk_o = hi_pos_q;
  end

  assign pix_en_o = en_q;

endmodule

// File: rtl/pcd_pair.sv
module pcd_pair
  import pcd_pkg::*;
#(
  parameter  int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CHW-1:0]    wr_ch_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic [NSRC-2:0]   src_tick_i,
  output logic [NCH-1:0]    pix_clk_o,
  output logic [NCH-1:0]    pix_en_o,
  output logic [NCH-1:0]    pix_int_o
);

  ctrl_t                      wr_w;
  ctrl_t [NCH-1:0]            shadow_w;
  logic  [NCH-1:0]            hit_w;
  logic  [NCH-1:0]            end_w;
  logic  [NCH-1:0]            tick_w;
  logic  [NCH-1:0][RAT_W-1:0] ratio_w;

  assign wr_w = ctrl_t'(wr_data_i);

  pcd_ctrl_bank #(.NCH(NCH), .CHW(CHW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_ch_i   (wr_ch_i),
    .wr_data_i (wr_w),
    .shadow_o  (shadow_w),
    .hit_o     (hit_w)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign pix_int_o[ch] = shadow_w[ch].internal;

    pcd_divider u_div (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .shadow_i     (timing_of(shadow_w[ch])),
      .hit_i        (hit_w[ch]),
      .wr_i         (timing_of(wr_w)),
      .ticks_i      (src_tick_i),
      .pix_clk_o    (pix_clk_o[ch]),
      .pix_en_o     (pix_en_o[ch]),
      .period_end_o (end_w[ch]),
      .tick_o       (tick_w[ch]),
      .ratio_o      (ratio_w[ch])
    );
  end

endmodule

// File: rtl/pcd_pair_chk.sv
module pcd_pair_chk
  import pcd_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NCH-1:0]            pix_clk_o,
  input logic [NCH-1:0]            pix_en_o,
  input logic [NCH-1:0]            end_w,
  input logic [NCH-1:0]            tick_w,
  input logic [NCH-1:0][RAT_W-1:0] ratio_w
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic [RAT_W-1:0] ticks_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         ticks_seen_q <= '0;
      else if (end_w[g])   ticks_seen_q <= '0;
      else if (tick_w[g])  ticks_seen_q <= ticks_seen_q + RAT_W'(1);
    end

    AST_PERIOD_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_w[g] |-> (ticks_seen_q + RAT_W'(1)) == ratio_w[g]);        // R1

    AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !end_w[g] |=> $stable(ratio_w[g]));                            // R8

    AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pix_en_o[g] && ratio_w[g] != RAT_W'(1)) |-> pix_clk_o[g]);    // R10

    AST_RESET_DIV2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> ratio_w[g] == RAT_W'(2));                    // R3
  end

endmodule

bind pcd_pair pcd_pair_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pix_clk_o (pix_clk_o),
  .pix_en_o  (pix_en_o),
  .end_w     (end_w),
  .tick_w    (tick_w),
  .ratio_w   (ratio_w)
);

// File: tb/pcd_pair_test.sv
module pcd_pair_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_ch = '0;
  logic [8:0] wr_data = '0;
  logic [2:0] ticks = '0;
  logic [1:0] pix_clk, pix_en, pix_int;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  pcd_pair uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_data_i(wr_data), .src_tick_i(ticks),
    .pix_clk_o(pix_clk), .pix_en_o(pix_en), .pix_int_o(pix_int)
  );

  // source 1 ticks every second cycle, sources 2 and 3 stay idle
  initial forever begin
    @(negedge clk);
    ticks[0] = ~ticks[0];
  end

  function automatic logic [8:0] word(int src, int intl, int byp, int dv);
    return {src[1:0], intl[0], byp[0], dv[4:0]};
  endfunction

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic half();
    @(posedge clk or negedge clk);
    #1;
  endtask

  task automatic write(int ch, logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch[0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // half-cycle samples of one period: length, high samples, enable pulses
  task automatic measure(int ch, output int per, output int hi, output int ens);
    logic p;
    per = 0; hi = 0; ens = 0;
    half();
    p = pix_clk[ch];
    for (int g = 0; g < 300; g++) begin
      half();
      if (!p && pix_clk[ch]) break;
      p = pix_clk[ch];
    end
    for (int g = 0; g < 300; g++) begin
      per++;
      if (pix_clk[ch]) hi++;
      if (!clk && pix_en[ch]) ens++;
      p = pix_clk[ch];
      half();
      if (!p && pix_clk[ch]) break;
    end
  endtask

  task automatic settle(int ch, output int per, output int hi, output int ens);
    measure(ch, per, hi, ens);
    measure(ch, per, hi, ens);
  endtask

  task automatic halves_to_rise(int ch, output int n);
    logic p;
    #1;
    p = pix_clk[ch];
    n = 0;
    for (int g = 0; g < 300; g++) begin
      half();
      n++;
      if (!p && pix_clk[ch]) break;
      p = pix_clk[ch];
    end
  endtask

  task automatic wait_en(int ch);
    for (int g = 0; g < 300 && !(clk && !pix_en[ch]); g++) half();
    for (int g = 0; g < 300 && !(clk && pix_en[ch]); g++) half();
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    int per, hi, ens, n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R3 type bit after reset", int'(pix_int), 0);
    settle(0, per, hi, ens);
    chk("R3 ch0 default period", per, 4);
    chk("R3 ch0 default high", hi, 2);
    settle(1, per, hi, ens);
    chk("R3 ch1 default period", per, 4);

    // R1 R4 R10: every divisor on the reference source
    for (int d = 0; d < 32; d++) begin
      write(0, word(0, 0, 0, d));
      settle(0, per, hi, ens);
      chk($sformatf("R1 period div=%0d", d), per, 2 * (d + 2));
      chk($sformatf("R4 high div=%0d", d), hi, d + 2);
      chk($sformatf("R10 pulses div=%0d", d), ens, 1);
    end
    settle(1, per, hi, ens);
    chk("R7 ch1 untouched by ch0 writes", per, 4);

    // R2 R6: bypass ignores the divisor field
    write(0, word(0, 1, 1, 17));
    #1;
    chk("R6 type bit ch0", int'(pix_int[0]), 1);
    chk("R7 type bit ch1", int'(pix_int[1]), 0);
    settle(0, per, hi, ens);
    chk("R2 bypass period", per, 2);
    chk("R2 bypass high", hi, 1);
    chk("R10 bypass pulses", ens, 1);
    write(0, word(0, 0, 1, 0));
    #1;
    chk("R6 type bit cleared", int'(pix_int[0]), 0);
    settle(0, per, hi, ens);
    chk("R2 bypass period div=0", per, 2);

    // R5: slower parent on source code 1
    write(1, word(1, 0, 0, 1));
    settle(1, per, hi, ens);
    chk("R5 tick source ratio 3 period", per, 12);
    chk("R5 tick source ratio 3 high", hi, 8);
    chk("R10 tick source pulses", ens, 1);
    write(1, word(1, 0, 0, 0));
    settle(1, per, hi, ens);
    chk("R5 tick source ratio 2 period", per, 8);
    chk("R5 tick source ratio 2 high", hi, 4);
    settle(0, per, hi, ens);
    chk("R7 ch0 still bypassed", per, 2);

    // R8: write four cycles into a ratio-10 period
    write(0, word(0, 0, 0, 8));
    settle(0, per, hi, ens);
    chk("R1 ratio 10 period", per, 20);
    wait_en(0);
    repeat (3) @(posedge clk);
    write(0, word(0, 0, 0, 2));
    halves_to_rise(0, n);
    chk("R8 old period completes", n, 11);
    measure(0, per, hi, ens);
    chk("R8 new ratio 4 next period", per, 8);

    // R9: write accepted on the edge that closes a ratio-4 period
    wait_en(0);
    repeat (3) @(posedge clk);
    write(0, word(0, 0, 0, 4));
    halves_to_rise(0, n);
    chk("R9 forwarded into new period", n, 11);
    measure(0, per, hi, ens);
    chk("R9 ratio 6 period", per, 12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule